// File: doc/BRIEF.md
# Programmable IR Carrier Generator

This block produces a rectangular carrier for an infrared transmitter. Software sets the high time and the low time separately, in units of a prescaled bus clock, and so fixes both the frequency and the duty cycle. A 2-bit divide field sets one count to 1, 2, 4 or 8 bus cycles. Every period starts with its high phase. A period lasts the high count plus the low count. Count values are latched only at period boundaries, so a period is never cut short or stretched part way through.

The block has three ways of running. In timed operation it uses the primary high/low pair. In baseband operation the carrier is forced high for as long as the generator runs. In frequency-shift operation it swaps between the primary and secondary pairs whenever an external modulator sends a toggle strobe. The swap happens at the next period boundary. An output-pin stage picks what drives the pin: the generator, a level written by software, or nothing at all. When nothing drives the pin, the generator can still run as a bare timer.

The configuration inputs are plain register values. The block has no streaming data path, so it has no valid/ready handshake.

Top module: `ir_carrier_gen`

## Requirements
- R1: While reset is asserted, and right after it, `carrier_out`, `pin_out` and `pin_oe` are low, whatever the other inputs are.
- R2: One count lasts 2^`div_sel` bus cycles. `div_sel`=0,1,2,3 gives 1, 2, 4 or 8 cycles.
- R3: After `gen_en` rises, the first clock edge starts a period in the high phase. `carrier_out` is high for hi×2^div cycles, then low for lo×2^div cycles, and this repeats.
- R4: A high or low count of 0 behaves exactly like a count of 1.
- R5: A change to the count registers during a period takes effect only when the next period begins.
- R6: While `base_mode`=1 and the generator runs, `carrier_out` stays high.
- R7: While `fsk_mode`=1, a `fsk_toggle` pulse seen during a period makes the next period use the other pair. Pair A is `hi_a`/`lo_a` and pair B is `hi_b`/`lo_b`. Several pulses within one period cause a single swap. Without pulses, the pair in use is kept.
- R8: While `fsk_mode`=0, `fsk_toggle` is ignored and pair A is used. After `gen_en` is re-asserted, the first period always uses pair A.
- R9: When `gen_en` falls, `carrier_out` is low from the next clock edge on.
- R10: When `pin_en`=1 and `gen_en`=1, `pin_oe`=1 and `pin_out` equals `carrier_out` delayed by one clock.
- R11: When `pin_en`=1 and `gen_en`=0, `pin_out` equals `sw_level` delayed by one clock.
- R12: When `pin_en`=0, `pin_oe` and `pin_out` are 0 one clock later, while `carrier_out` keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Generator enable |
| div_sel | input | 2 | Count resolution select, 2^div_sel cycles per count |
| base_mode | input | 1 | Force carrier high (baseband) |
| fsk_mode | input | 1 | Enable pair swapping on toggle strobes |
| fsk_toggle | input | 1 | Toggle strobe from the modulator |
| hi_a | input | 8 | Primary high count |
| lo_a | input | 8 | Primary low count |
| hi_b | input | 8 | Secondary high count |
| lo_b | input | 8 | Secondary low count |
| pin_en | input | 1 | Pin drive enable |
| sw_level | input | 1 | Software pin level used while the generator is off |
| carrier_out | output | 1 | Carrier waveform |
| pin_out | output | 1 | Registered pin value |
| pin_oe | output | 1 | Registered pin output-enable |

## Verification
The waveform is checked cycle by cycle against a sweep. The sweep covers every divide setting and every high and low count from 0 to 4, over two periods each. This separates the effect of the prescaler from the high/low split, and it shows whether a zero count is clamped rather than wrapped. One directed case rewrites the counts in the middle of a high phase, to show that changes wait for the boundary. Frequency-shift cases use pairs with different periods: single pulses, double pulses within one period, and pulses with shifting turned off. They tell a missed swap, a swap counted twice and a wrongly accepted pulse apart from each other. The pin is checked in each of its three source settings.

// File: rtl/irc_pkg.sv
package irc_pkg;
  parameter int unsigned IRC_CNT_W = 8;
  parameter int unsigned IRC_DIV_W = 2;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } irc_phase_e;
endpackage

// File: rtl/irc_prescaler.sv
module irc_prescaler #(
  parameter int unsigned DIV_W = irc_pkg::IRC_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  localparam int unsigned PS_W = (1 << DIV_W) - 1;

  logic [PS_W-1:0] ps_cnt;
  logic [PS_W-1:0] ps_lim;

  // limit = 2^div_sel - 1, built as a thermometer code
  always_comb begin
    ps_lim = '0;
    for (int i = 0; i < PS_W; i++) begin
      ps_lim[i] = (DIV_W'(i) < div_sel);
    end
  end

  assign tick = en && (ps_cnt == ps_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_cnt <= '0;
    end else if (!en || tick) begin
      ps_cnt <= '0;
    end else begin
      ps_cnt <= ps_cnt + 1'b1;
    end
  end

  // with a divide above one, ticks are never back to back unless div changed
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_sel != '0) |=> (!tick || div_sel != $past(div_sel)));
endmodule

// File: rtl/irc_carrier_core.sv
module irc_carrier_core #(
  parameter int unsigned CNT_W = irc_pkg::IRC_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             tick,
  input  logic             base_mode,
  input  logic             fsk_mode,
  input  logic             fsk_toggle,
  input  logic [CNT_W-1:0] hi_a,
  input  logic [CNT_W-1:0] lo_a,
  input  logic [CNT_W-1:0] hi_b,
  input  logic [CNT_W-1:0] lo_b,
  output logic             running,
  output logic             carrier
);
  import irc_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  irc_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] hi_lat;
  logic [CNT_W-1:0] lo_lat;
  logic             run_q;
  logic             sel_q;
  logic             pend_q;

  logic [CNT_W-1:0] cur_len;
  logic             phase_end;
  logic             next_sel;
  logic [CNT_W-1:0] nxt_hi;
  logic [CNT_W-1:0] nxt_lo;

  assign cur_len   = (phase_q == PH_HIGH) ? hi_lat : lo_lat;
  assign phase_end = (cnt_q == cur_len);
  assign next_sel  = fsk_mode ? (sel_q ^ (pend_q | fsk_toggle)) : 1'b0;
  assign nxt_hi    = next_sel ? clamp_cnt(hi_b) : clamp_cnt(hi_a);
  assign nxt_lo    = next_sel ? clamp_cnt(lo_b) : clamp_cnt(lo_a);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      phase_q <= PH_LOW;
      cnt_q   <= '0;
      hi_lat  <= '0;
      lo_lat  <= '0;
      sel_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else if (!gen_en) begin
      run_q   <= 1'b0;
      phase_q <= PH_LOW;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else if (!run_q) begin
      run_q   <= 1'b1;
      phase_q <= PH_HIGH;
      cnt_q   <= ONE;
      sel_q   <= 1'b0;
      pend_q  <= 1'b0;
      hi_lat  <= clamp_cnt(hi_a);
      lo_lat  <= clamp_cnt(lo_a);
    end else begin
      if (fsk_toggle) begin
        pend_q <= 1'b1;
      end
      if (tick) begin
        if (!phase_end) begin
          cnt_q <= cnt_q + ONE;
        end else if (phase_q == PH_HIGH) begin
          phase_q <= PH_LOW;
          cnt_q   <= ONE;
        end else begin
          phase_q <= PH_HIGH;
          cnt_q   <= ONE;
          sel_q   <= next_sel;
          pend_q  <= 1'b0;
          hi_lat  <= nxt_hi;
          lo_lat  <= nxt_lo;
        end
      end
    end
  end

  assign running = run_q;
  assign carrier = run_q && (base_mode || phase_q == PH_HIGH);

  // phase counter never leaves 1..length while running
  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q >= ONE && cnt_q <= cur_len));
  // latched lengths only move when a fresh period has just begun
  assert_latch_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hi_lat) |-> (phase_q == PH_HIGH && cnt_q == ONE));
  // pair selection only moves at a period start or when stopped
  assert_sel_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> (!run_q || (phase_q == PH_HIGH && cnt_q == ONE)));
  // disabling silences the carrier at the next edge
  assert_off_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !carrier);
endmodule

// File: rtl/irc_pin_drive.sv
module irc_pin_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_en,
  input  logic gen_en,
  input  logic carrier,
  input  logic sw_level,
  output logic pin_out,
  output logic pin_oe
);
  logic src;

  assign src = gen_en ? carrier : sw_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
    end else begin
      pin_out <= pin_en & src;
      pin_oe  <= pin_en;
    end
  end

  assert_oe_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pin_oe == $past(pin_en)));
  assert_dark_pin_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en |=> !pin_out);
  assert_sw_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en && !gen_en) |=> (pin_out == $past(sw_level)));
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
  parameter int unsigned CNT_W = irc_pkg::IRC_CNT_W,
  parameter int unsigned DIV_W = irc_pkg::IRC_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             base_mode,
  input  logic             fsk_mode,
  input  logic             fsk_toggle,
  input  logic [CNT_W-1:0] hi_a,
  input  logic [CNT_W-1:0] lo_a,
  input  logic [CNT_W-1:0] hi_b,
  input  logic [CNT_W-1:0] lo_b,
  input  logic             pin_en,
  input  logic             sw_level,
  output logic             carrier_out,
  output logic             pin_out,
  output logic             pin_oe
);
  logic running;
  logic tick;

  irc_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (running),
    .div_sel (div_sel),
    .tick    (tick)
  );

  irc_carrier_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen_en     (gen_en),
    .tick       (tick),
    .base_mode  (base_mode),
    .fsk_mode   (fsk_mode),
    .fsk_toggle (fsk_toggle),
    .hi_a       (hi_a),
    .lo_a       (lo_a),
    .hi_b       (hi_b),
    .lo_b       (lo_b),
    .running    (running),
    .carrier    (carrier_out)
  );

  irc_pin_drive u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_en   (pin_en),
    .gen_en   (gen_en),
    .carrier  (carrier_out),
    .sw_level (sw_level),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  assert_base_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && base_mode) |-> carrier_out);
endmodule

// File: tb/ir_carrier_gen_bench.sv
`timescale 1ns/1ps
module ir_carrier_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gen_en = 1'b0;
  logic [1:0] div_sel = '0;
  logic       base_mode = 1'b0;
  logic       fsk_mode = 1'b0;
  logic       fsk_toggle = 1'b0;
  logic [7:0] hi_a = '0, lo_a = '0, hi_b = '0, lo_b = '0;
  logic       pin_en = 1'b0;
  logic       sw_level = 1'b0;
  logic       carrier_out, pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ir_carrier_gen u_ir_carrier_gen (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .div_sel(div_sel),
    .base_mode(base_mode), .fsk_mode(fsk_mode), .fsk_toggle(fsk_toggle),
    .hi_a(hi_a), .lo_a(lo_a), .hi_b(hi_b), .lo_b(lo_b),
    .pin_en(pin_en), .sw_level(sw_level),
    .carrier_out(carrier_out), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expc(int k, int eh, int el, int r);
    if (k < 0) return 0;
    return ((k % ((eh + el) * r)) < eh * r) ? 1 : 0;
  endfunction

  task automatic stop_gen();
    @(negedge clk);
    gen_en = 1'b0;
    fsk_toggle = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // enable, then sample at the negedge after each following posedge
  task automatic start_gen();
    gen_en = 1'b1;
    @(posedge clk);
  endtask

  task automatic sweep_one(input int d, input int h, input int l);
    int eh, el, r, per, badc, badp, firstk, acts, exps;
    eh = (h == 0) ? 1 : h;
    el = (l == 0) ? 1 : l;
    r = 1 << d;
    per = (eh + el) * r;
    badc = 0; badp = 0; firstk = -1; acts = 0; exps = 0;
    stop_gen();
    div_sel = 2'(d); hi_a = 8'(h); lo_a = 8'(l);
    hi_b = 8'd9; lo_b = 8'd9; pin_en = 1'b1; fsk_mode = 1'b0; base_mode = 1'b0;
    start_gen();
    for (int k = 0; k < 2 * per; k++) begin
      @(negedge clk);
      if (int'(carrier_out) != expc(k, eh, el, r)) begin
        if (firstk < 0) begin firstk = k; acts = carrier_out; exps = expc(k, eh, el, r); end
        badc++;
      end
      if (int'(pin_out) != expc(k - 1, eh, el, r) || !pin_oe) badp++;
    end
    // R2 R3 R4: waveform over two periods
    checks++;
    if (badc != 0) begin
      errors++;
      $display("FAIL R2/R3/R4 div=%0d hi=%0d lo=%0d cycle %0d actual=%0d expected=%0d",
               d, h, l, firstk, acts, exps);
    end
    // R10: pin follows carrier one clock late
    checks++;
    if (badp != 0) begin
      errors++;
      $display("FAIL R10 div=%0d hi=%0d lo=%0d mismatches actual=%0d expected=0", d, h, l, badp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int exp_arr[20];
    // R1: reset holds outputs low even with pin driven by software
    pin_en = 1'b1; sw_level = 1'b1; gen_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 carrier", carrier_out, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 pin_out", pin_out, 0);
    rst_n = 1'b1;
    pin_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 carrier after release", carrier_out, 0);
    chk("R1 pin_oe after release", pin_oe, 0);

    // R11: software level on the pin
    pin_en = 1'b1; sw_level = 1'b1;
    @(negedge clk);
    chk("R11 pin_out high", pin_out, 1);
    chk("R11 pin_oe", pin_oe, 1);
    sw_level = 1'b0;
    @(negedge clk);
    chk("R11 pin_out low", pin_out, 0);

    // R2 R3 R4 R10: sweep every divide and counts 0..4
    for (int d = 0; d < 4; d++)
      for (int h = 0; h < 5; h++)
        for (int l = 0; l < 5; l++)
          sweep_one(d, h, l);

    // R9: disable silences carrier at next edge
    @(negedge clk);
    gen_en = 1'b0;
    @(negedge clk);
    chk("R9 carrier after disable", carrier_out, 0);

    // R5: counts rewritten mid-period wait for the boundary
    stop_gen();
    div_sel = 2'd0; hi_a = 8'd2; lo_a = 8'd2;
    exp_arr = '{1,1,0,0,1,1,1,1,0,1,1,1,1,0,0,0,0,0,0,0};
    start_gen();
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      chk($sformatf("R5 cycle %0d", k), carrier_out, exp_arr[k]);
      if (k == 0) begin hi_a = 8'd4; lo_a = 8'd1; end
    end

    // R6: baseband keeps carrier high
    stop_gen();
    hi_a = 8'd1; lo_a = 8'd3; base_mode = 1'b1;
    start_gen();
    begin
      int lows = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (!carrier_out) lows++;
      end
      chk("R6 low cycles under baseband", lows, 0);
    end
    base_mode = 1'b0;

    // R7: pair swapping on toggle strobes
    stop_gen();
    hi_a = 8'd1; lo_a = 8'd1; hi_b = 8'd3; lo_b = 8'd3; fsk_mode = 1'b1;
    exp_arr = '{1,0,1,1,1,0,0,0,1,1,1,0,0,0,1,0,1,0,0,0};
    start_gen();
    for (int k = 0; k < 17; k++) begin
      @(negedge clk);
      chk($sformatf("R7 cycle %0d", k), carrier_out, exp_arr[k]);
      fsk_toggle = (k == 0 || k == 9 || k == 11);
    end
    fsk_toggle = 1'b0;

    // R8: re-enable starts on pair A although B was active
    stop_gen();
    fsk_toggle = 1'b1;
    @(negedge clk);
    fsk_toggle = 1'b0;
    start_gen();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk($sformatf("R8 restart cycle %0d", k), carrier_out, (k % 2 == 0) ? 1 : 0);
    end

    // R8: toggles ignored with shifting off
    stop_gen();
    fsk_mode = 1'b0;
    start_gen();
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk($sformatf("R8 no-shift cycle %0d", k), carrier_out, (k % 2 == 0) ? 1 : 0);
      fsk_toggle = (k % 3 == 0);
    end
    fsk_toggle = 1'b0;

    // R12: pin dark while generator keeps running
    @(negedge clk);
    pin_en = 1'b0;
    begin
      int highs = 0, pinh = 0, oeh = 0;
      @(negedge clk);
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        highs += carrier_out;
        pinh += pin_out;
        oeh += pin_oe;
      end
      chk("R12 pin_oe high count", oeh, 0);
      chk("R12 pin_out high count", pinh, 0);
      chk("R12 carrier still toggling", highs, 5);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule